// File: doc/BRIEF.md
# NAND Page Operation Sequencer

This block turns one high-level flash request into the ordered stream of bus cycles that a large-page, 8-bit NAND device expects. The four requests are read identifier, read page, program page and erase block. Each request carries a block number and a page number. Every command, address, write and read cycle is handed one at a time to a separate bus timing generator through a request/accept handshake. Between phases the block holds off while the device reports busy, and after program or erase it polls the device status and reports pass or fail.

A page is 2048 main bytes followed by a 64-byte spare area, and the block streams all 2112 bytes without interpreting them. In the spare area, byte 0 is the bad-block marker (0xFF for a good block) and bytes 1 to 4 hold the main ECC, least significant byte first. Producing and checking those bytes is left to the neighbouring logic. Write data enters through a valid/ready input stream. Read data, including the two identifier bytes, leaves through a valid/ready output stream. A single-cycle done pulse with a fail flag closes every accepted request.

Top module: `nand_page_seq`

## Requirements
- R1: A read-page request issues command 0x00, four address cycles, command 0x30, waits for ready, then performs 2112 read cycles, and presents the returned bytes in order on the output stream, each held stable until taken.
- R2: The row address is block × 64 + page (64 pages per block). It is sent low byte first as the third and fourth address cycles. The first two address cycles (column) carry 0x00.
- R3: A program request issues command 0x80 and the same four address cycles, then 2112 write cycles carrying the input stream bytes in order, then command 0x10. It waits for ready, then issues command 0x70 and one status read.
- R4: An erase request issues command 0x60, then only the two row address bytes, then command 0xD0, waits for ready, then issues command 0x70 and one status read.
- R5: For program and erase, a status byte with bit 0 set ends the request with fail=1; bit 0 clear gives fail=0. Read requests complete with fail=0 when no illegal access occurs.
- R6: The status read cycle is requested no earlier than TWHR_CYC clock cycles (default 6, i.e. 60 ns at 100 MHz) after the 0x70 command cycle is accepted.
- R7: A read-identifier request issues command 0x90 and one address cycle 0x00, then two read cycles. The maker byte is presented first and the device byte second.
- R8: If ill_acc is high while the block waits for ready, the request ends at once with done and fail=1. No further data or status cycles are issued.
- R9: ce_n is low from the cycle after a request is accepted until done, on every path, and high in the cycle after done. No bus cycle is requested while ce_n is high.
- R10: Exactly one done pulse follows each accepted request. req_valid is ignored while a request is in flight.
- R11: After a confirm command (0x30, 0x10, 0xD0), no bus cycle is requested while rb_n is low. The wait lasts at least TWB_CYC cycles before rb_n is trusted.
- R12: A command, address or read cycle request, once raised, keeps its kind and data until cyc_ready accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_op | input | 2 | 0 read id, 1 read page, 2 program, 3 erase |
| req_block | input | BLK_W | Block number |
| req_page | input | 6 | Page within block |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Result flag, valid with done |
| cyc_valid | output | 1 | Bus cycle request |
| cyc_kind | output | 2 | 0 command, 1 address, 2 write, 3 read |
| cyc_data | output | 8 | Command, address or write byte |
| cyc_ready | input | 1 | Bus cycle accepted (read byte valid on bus_rdata) |
| bus_rdata | input | 8 | Byte returned by a read cycle |
| ce_n | output | 1 | Chip enable, active low |
| rb_n | input | 1 | Device ready (1) / busy (0) |
| ill_acc | input | 1 | Illegal-access flag from the controller |
| wr_valid | input | 1 | Write stream byte available |
| wr_data | input | 8 | Write stream byte |
| wr_ready | output | 1 | Write stream byte consumed |
| out_valid | output | 1 | Read stream byte available |
| out_data | output | 8 | Read stream byte |
| out_ready | input | 1 | Read stream byte taken |

## Verification
Every bus cycle is logged at the clock edge where cyc_valid and cyc_ready meet, and the log for a request is compared with a sequence built by the bench from R1–R4 and R7 once done has been seen. The done flag is sampled in the one cycle it is high. ce_n is sampled one cycle later, where R9 expects it high again. The status gap is measured as the number of cycles between the 0x70 acceptance and the status read acceptance and must be at least 6. Extra done pulses are looked for over four further cycles. All sampling happens between clock edges, after the bench has settled its inputs for that cycle.

// File: rtl/nand_page_seq.sv
module nand_page_seq #(
  parameter int BLK_W           = 10,
  parameter int PAGES_PER_BLOCK = 64,
  parameter int MAIN_BYTES      = 2048,
  parameter int SPARE_BYTES     = 64,
  parameter int TWB_CYC         = 4,
  parameter int TWHR_CYC        = 6,
  localparam int PG_W           = $clog2(PAGES_PER_BLOCK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic [BLK_W-1:0] req_block,
  input  logic [PG_W-1:0]  req_page,
  output logic             done,
  output logic             fail,
  output logic             cyc_valid,
  output logic [1:0]       cyc_kind,
  output logic [7:0]       cyc_data,
  input  logic             cyc_ready,
  input  logic [7:0]       bus_rdata,
  output logic             ce_n,
  input  logic             rb_n,
  input  logic             ill_acc,
  input  logic             wr_valid,
  input  logic [7:0]       wr_data,
  output logic             wr_ready,
  output logic             out_valid,
  output logic [7:0]       out_data,
  input  logic             out_ready
);
  localparam int PAGE_BYTES = MAIN_BYTES + SPARE_BYTES;
  localparam int ROW_W      = BLK_W + PG_W;
  localparam int CNT_W      = $clog2(PAGE_BYTES);
  localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(PAGE_BYTES - 1);
  localparam logic [CNT_W-1:0] WB_LIM    = CNT_W'(TWB_CYC);
  localparam logic [CNT_W-1:0] WHR_LIM   = CNT_W'(TWHR_CYC - 1);

  localparam logic [1:0] OP_ID = 2'd0, OP_READ = 2'd1, OP_PROG = 2'd2, OP_ERASE = 2'd3;
  localparam logic [1:0] K_CMD = 2'd0, K_ADDR = 2'd1, K_WR = 2'd2, K_RD = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD1, S_ADDR, S_WDATA, S_CMD2, S_WAITRB,
    S_STCMD, S_GAP, S_STRD, S_RDATA, S_RHOLD, S_FIN
  } state_t;

  state_t           st;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       op;
  logic [ROW_W-1:0] row;
  logic [15:0]      row_b;
  logic             fail_q;
  logic [7:0]       rbyte;
  logic             fire;
  logic             addr_last;
  logic             rd_last;

  assign row_b     = 16'(row);
  assign done      = (st == S_FIN);
  assign fail      = fail_q;
  assign ce_n      = (st == S_IDLE);
  assign out_valid = (st == S_RHOLD);
  assign out_data  = rbyte;
  assign wr_ready  = (st == S_WDATA) && cyc_ready;
  assign fire      = cyc_valid && cyc_ready;
  assign addr_last = (op == OP_ID) ? (cnt == '0) : (cnt == CNT_W'(3));
  assign rd_last   = (op == OP_ID) ? (cnt == CNT_W'(1)) : (cnt == LAST_BYTE);

  always_comb begin
    cyc_valid = 1'b0;
    cyc_kind  = K_CMD;
    cyc_data  = 8'h00;
    case (st)
      S_CMD1: begin
        cyc_valid = 1'b1;
        case (op)
          OP_ID:   cyc_data = 8'h90;
          OP_READ: cyc_data = 8'h00;
          OP_PROG: cyc_data = 8'h80;
          default: cyc_data = 8'h60;
        endcase
      end
      S_ADDR: begin
        cyc_valid = 1'b1;
        cyc_kind  = K_ADDR;
        case (cnt[1:0])
          2'd2:    cyc_data = row_b[7:0];
          2'd3:    cyc_data = row_b[15:8];
          default: cyc_data = 8'h00;
        endcase
      end
      S_WDATA: begin
        cyc_valid = wr_valid;
        cyc_kind  = K_WR;
        cyc_data  = wr_data;
      end
      S_CMD2: begin
        cyc_valid = 1'b1;
        case (op)
          OP_READ: cyc_data = 8'h30;
          OP_PROG: cyc_data = 8'h10;
          default: cyc_data = 8'hD0;
        endcase
      end
      S_STCMD: begin
        cyc_valid = 1'b1;
        cyc_data  = 8'h70;
      end
      S_STRD, S_RDATA: begin
        cyc_valid = 1'b1;
        cyc_kind  = K_RD;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      op     <= OP_ID;
      row    <= '0;
      fail_q <= 1'b0;
      rbyte  <= 8'h00;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          op     <= req_op;
          row    <= {req_block, req_page};
          fail_q <= 1'b0;
          cnt    <= (req_op == OP_ERASE) ? CNT_W'(2) : '0;
          st     <= S_CMD1;
        end
        S_CMD1: if (fire) st <= S_ADDR;
        S_ADDR: if (fire) begin
          if (addr_last) begin
            cnt <= '0;
            st  <= (op == OP_ID) ? S_RDATA : (op == OP_PROG) ? S_WDATA : S_CMD2;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        S_WDATA: if (fire) begin
          if (cnt == LAST_BYTE) begin
            cnt <= '0;
            st  <= S_CMD2;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        S_CMD2: if (fire) begin
          cnt <= '0;
          st  <= S_WAITRB;
        end
        S_WAITRB: begin
          if (ill_acc) begin
            fail_q <= 1'b1;
            st     <= S_FIN;
          end else if (cnt != WB_LIM) begin
            cnt <= cnt + CNT_W'(1);
          end else if (rb_n) begin
            cnt <= '0;
            st  <= (op == OP_READ) ? S_RDATA : S_STCMD;
          end
        end
        S_STCMD: if (fire) begin
          cnt <= '0;
          st  <= S_GAP;
        end
        S_GAP: begin
          if (cnt == WHR_LIM) st <= S_STRD;
          else cnt <= cnt + CNT_W'(1);
        end
        S_STRD: if (fire) begin
          fail_q <= bus_rdata[0];
          st     <= S_FIN;
        end
        S_RDATA: if (fire) begin
          rbyte <= bus_rdata;
          st    <= S_RHOLD;
        end
        S_RHOLD: if (out_ready) begin
          if (rd_last) begin
            st <= S_FIN;
          end else begin
            cnt <= cnt + CNT_W'(1);
            st  <= S_RDATA;
          end
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_page_seq_chk.sv
module nand_page_seq_chk #(
  parameter int TWHR_CYC = 6
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       done,
  input logic       fail,
  input logic       cyc_valid,
  input logic [1:0] cyc_kind,
  input logic [7:0] cyc_data,
  input logic       cyc_ready,
  input logic       ce_n,
  input logic       rb_n,
  input logic       ill_acc,
  input logic       out_valid,
  input logic [7:0] out_data,
  input logic       out_ready
);
  logic       inflight;
  logic       gap_armed;
  logic [7:0] gap_cnt;
  logic       wait_armed;
  logic       fire;
  logic       is_confirm;

  assign fire       = cyc_valid && cyc_ready;
  assign is_confirm = fire && (cyc_kind == 2'd0) &&
                      (cyc_data == 8'h30 || cyc_data == 8'h10 || cyc_data == 8'hD0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inflight   <= 1'b0;
      gap_armed  <= 1'b0;
      gap_cnt    <= 8'd0;
      wait_armed <= 1'b0;
    end else begin
      if (done) inflight <= 1'b0;
      else if (req_valid && ce_n) inflight <= 1'b1;
      if (fire && cyc_kind == 2'd0 && cyc_data == 8'h70) begin
        gap_armed <= 1'b1;
        gap_cnt   <= 8'd0;
      end else begin
        if (fire && cyc_kind == 2'd3) gap_armed <= 1'b0;
        if (gap_cnt != 8'hFF) gap_cnt <= gap_cnt + 8'd1;
      end
      if (is_confirm) wait_armed <= 1'b1;
      else if (fire || done) wait_armed <= 1'b0;
    end
  end

  AST_CE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ce_n); // R9
  AST_CYC_WITH_CE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |-> !ce_n); // R9
  AST_DONE_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> inflight); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_CYC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && !cyc_ready && cyc_kind != 2'd2) |=>
      (cyc_valid && $stable(cyc_kind) && $stable(cyc_data))); // R12
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R1
  AST_STATUS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_armed && cyc_valid && cyc_kind == 2'd3) |-> (gap_cnt >= 8'(TWHR_CYC))); // R6
  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_armed && !rb_n) |-> !cyc_valid); // R11
  AST_ILL_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_armed && !cyc_valid && !done && ill_acc) |=> (done && fail)); // R8
endmodule

bind nand_page_seq nand_page_seq_chk #(.TWHR_CYC(TWHR_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .done(done), .fail(fail),
  .cyc_valid(cyc_valid), .cyc_kind(cyc_kind), .cyc_data(cyc_data),
  .cyc_ready(cyc_ready), .ce_n(ce_n), .rb_n(rb_n), .ill_acc(ill_acc),
  .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
);

// File: tb/tb_nand_page_seq.sv
module tb_nand_page_seq;
  localparam int BLK_W = 10;
  localparam int NBYTES = 2112;
  localparam int BUSY_LEN = 20;
  localparam logic [7:0] MAKER = 8'hA5, DEVID = 8'h3C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [BLK_W-1:0] req_block = '0;
  logic [5:0] req_page = '0;
  logic done, fail, cyc_valid, ce_n, wr_ready, out_valid;
  logic [1:0] cyc_kind;
  logic [7:0] cyc_data, out_data;
  logic cyc_ready = 1'b0, rb_n = 1'b1, ill_acc = 1'b0, wr_valid = 1'b0, out_ready = 1'b0;
  logic [7:0] bus_rdata = 8'h00, wr_data = 8'h00;

  always #5 clk = ~clk;

  nand_page_seq #(.BLK_W(BLK_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_block(req_block), .req_page(req_page), .done(done), .fail(fail),
    .cyc_valid(cyc_valid), .cyc_kind(cyc_kind), .cyc_data(cyc_data),
    .cyc_ready(cyc_ready), .bus_rdata(bus_rdata), .ce_n(ce_n), .rb_n(rb_n),
    .ill_acc(ill_acc), .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready));

  int checks = 0, fails = 0;
  int cycle = 0, n_log = 0, n_exp = 0, wr_idx = 0, rd_idx = 0, oidx = 0, omism = 0;
  int busy_cnt = 0, done_cnt = 0, rb_viol = 0, ce_viol = 0, t70 = 0, tst = 0;
  int cur_row = 0, salt = 0;
  bit ill_mode = 0, last_fail = 0;
  logic [7:0] last_cmd = 8'hFF, status_val = 8'h00;
  logic [1:0] log_k [0:2199];
  logic [7:0] log_d [0:2199];
  logic [1:0] exp_k [0:2199];
  logic [7:0] exp_d [0:2199];

  function automatic logic [7:0] ppat(int i, int r);
    return 8'(i * 3 + r + (i >> 8));
  endfunction
  function automatic logic [7:0] wpat(int i, int s);
    return 8'(i * 7 + s);
  endfunction

  task automatic check(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic push(logic [1:0] k, logic [7:0] d);
    exp_k[n_exp] = k;
    exp_d[n_exp] = d;
    n_exp++;
  endtask

  always @(negedge clk) if (rst_n) begin
    cyc_ready = ($urandom % 4) != 0;
    wr_valid  = ($urandom % 4) != 0;
    out_ready = ($urandom % 4) != 0;
    wr_data   = wpat(wr_idx, salt);
    if (last_cmd == 8'h70) bus_rdata = status_val;
    else if (last_cmd == 8'h90) bus_rdata = (rd_idx == 0) ? MAKER : DEVID;
    else bus_rdata = ppat(rd_idx, cur_row);
    if (busy_cnt > 0) busy_cnt--;
    rb_n = (busy_cnt == 0);
    ill_acc = ill_mode && (busy_cnt == 12);
    cycle++;
    #1;
    if (cyc_valid && !rb_n) rb_viol++;
    if (cyc_valid && cyc_ready) begin
      if (ce_n) ce_viol++;
      if (n_log < 2200) begin
        log_k[n_log] = cyc_kind;
        log_d[n_log] = (cyc_kind == 2'd3) ? 8'h00 : cyc_data;
        n_log++;
      end
      if (cyc_kind == 2'd0) begin
        last_cmd = cyc_data;
        rd_idx = 0;
        if (cyc_data == 8'h30 || cyc_data == 8'h10 || cyc_data == 8'hD0) busy_cnt = BUSY_LEN;
        if (cyc_data == 8'h70) t70 = cycle;
      end else if (cyc_kind == 2'd3) begin
        if (last_cmd == 8'h70) tst = cycle;
        rd_idx++;
      end else if (cyc_kind == 2'd2) begin
        wr_idx++;
      end
    end
    if (out_valid && out_ready) begin
      if (out_data !== ((last_cmd == 8'h90) ? ((oidx == 0) ? MAKER : DEVID) : ppat(oidx, cur_row)))
        omism++;
      oidx++;
    end
    if (done) begin
      done_cnt++;
      last_fail = fail;
    end
  end

  task automatic run_op(logic [1:0] op, int blk, int pg, logic [7:0] st, bit ill, bit probe);
    int row = blk * 64 + pg;
    int d0;
    int seq_bad = 0;
    int wd = 0;
    bit exp_fail;
    string tg;
    tg = (op == 0) ? "R7" : (op == 1) ? "R1" : (op == 2) ? "R3" : "R4";
    n_exp = 0;
    case (op)
      2'd0: begin push(0, 8'h90); push(1, 8'h00); push(3, 0); push(3, 0); end
      2'd1: begin
        push(0, 8'h00); push(1, 0); push(1, 0); push(1, 8'(row)); push(1, 8'(row >> 8));
        push(0, 8'h30);
        if (!ill) for (int i = 0; i < NBYTES; i++) push(3, 0);
      end
      2'd2: begin
        push(0, 8'h80); push(1, 0); push(1, 0); push(1, 8'(row)); push(1, 8'(row >> 8));
        for (int i = 0; i < NBYTES; i++) push(2, wpat(i, 8'(blk + pg)));
        push(0, 8'h10);
        if (!ill) begin push(0, 8'h70); push(3, 0); end
      end
      default: begin
        push(0, 8'h60); push(1, 8'(row)); push(1, 8'(row >> 8)); push(0, 8'hD0);
        if (!ill) begin push(0, 8'h70); push(3, 0); end
      end
    endcase
    exp_fail = ill ? 1'b1 : (op >= 2) ? st[0] : 1'b0;
    @(negedge clk);
    n_log = 0; oidx = 0; omism = 0; wr_idx = 0; salt = blk + pg;
    cur_row = row; status_val = st; ill_mode = ill; t70 = 0; tst = 0;
    d0 = done_cnt;
    req_op = op; req_block = BLK_W'(blk); req_page = 6'(pg); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (probe) begin
      repeat (3) @(negedge clk);
      req_op = 2'd0; req_valid = 1'b1;
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
    end
    while (done_cnt == d0 && wd < 20000) begin
      @(negedge clk); #2;
      wd++;
    end
    check(done_cnt == d0 + 1, "R10 done within watchdog", done_cnt - d0, 1);
    @(negedge clk); #2;
    check(ce_n == 1'b1, "R9 ce_n released after done", ce_n, 1);
    repeat (4) @(negedge clk);
    #2;
    check(done_cnt == d0 + 1, "R10 single done pulse", done_cnt - d0, 1);
    for (int i = 0; i < n_exp && i < n_log; i++)
      if (log_k[i] !== exp_k[i] || log_d[i] !== exp_d[i]) seq_bad++;
    check(n_log == n_exp, {tg, " R2 cycle count"}, n_log, n_exp);
    check(seq_bad == 0, {tg, " R2 cycle sequence"}, seq_bad, 0);
    check(last_fail == exp_fail, ill ? "R8 fail flag" : "R5 fail flag", last_fail, exp_fail);
    if (op <= 1 && !ill) begin
      check(oidx == ((op == 0) ? 2 : NBYTES), {tg, " output stream length"}, oidx, (op == 0) ? 2 : NBYTES);
      check(omism == 0, {tg, " output stream bytes"}, omism, 0);
    end
    if (op >= 2 && !ill)
      check(tst - t70 >= 6, "R6 status read gap", tst - t70, 6);
    check(ce_viol == 0, "R9 cycle with ce_n high", ce_viol, 0);
    check(rb_viol == 0, "R11 cycle during busy", rb_viol, 0);
    while (busy_cnt != 0) @(negedge clk);
    ill_mode = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    check(ce_n == 1'b1 && done == 1'b0, "R9 reset idle", ce_n, 1);
    check(cyc_valid == 1'b0 && out_valid == 1'b0, "R12 reset no cycle", cyc_valid, 0);
    run_op(2'd0, 0, 0, 8'h00, 0, 0);
    run_op(2'd1, 5, 63, 8'h00, 0, 0);
    run_op(2'd2, 1023, 0, 8'hE0, 0, 0);
    run_op(2'd2, 7, 9, 8'hC1, 0, 1);
    run_op(2'd3, 300, 0, 8'h00, 0, 0);
    run_op(2'd3, 1, 2, 8'h01, 0, 0);
    run_op(2'd1, 12, 4, 8'h00, 1, 0);
    run_op(2'd3, 44, 0, 8'h00, 1, 0);
    run_op(2'd2, 2, 33, 8'h00, 1, 0);
    for (int k = 0; k < 5; k++)
      run_op(2'($urandom % 4), int'($urandom % 1024), int'($urandom % 64),
             8'($urandom), 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule